// File: doc/BRIEF.md
# Bit-Manipulation Logic and Shift Unit

This block is a purely combinational 32-bit execution unit for the logic, shift, extension and single-bit operations of a processor's bit-manipulation extension. Two operands (`src_a` as the first source register, `src_b` as the second) and a 5-bit operation code enter; one 32-bit result leaves within the same cycle. It sits beside the main adder/shifter in an execute stage. The issuing pipeline decodes the instruction into the operation code and captures the result in its own registers.

The operations fall into three internal units. A logic unit holds the inverted-operand logic, the extensions, the per-byte OR-combine and the byte reversal. An arithmetic unit holds the shifted-add address forms and min/max. A rotate/bit unit holds the rotations and the single-bit clear, set, invert and extract. The top selects the unit that owns the current code. Counting operations, carry-less multiply, decode and register access live elsewhere.

Top module: `bitmanip_alu`

## Requirements
- R1: Code 0 gives `src_a & ~src_b`, code 1 gives `src_a | ~src_b`, code 2 gives `~(src_a ^ src_b)`.
- R2: Codes 3, 4 and 5 give `src_b + (src_a << N)` with N = 1, 2 and 3 respectively, truncated to 32 bits (wrap modulo 2^32).
- R3: Code 6 gives the signed minimum, code 7 the unsigned minimum, code 8 the signed maximum and code 9 the unsigned maximum of the two operands. The result is always one operand, unchanged.
- R4: Code 10 copies bit 7 of `src_a` into bits 31..8 above its low byte. Code 11 copies bit 15 into bits 31..16 above its low halfword. Code 12 keeps bits 15..0 and clears bits 31..16.
- R5: Code 13 rotates `src_a` left and code 14 rotates it right by the amount in `src_b`. An amount of 0 returns `src_a` unchanged.
- R6: Code 15 sets each result byte to 0xFF when the matching byte of `src_a` is nonzero, and to 0x00 otherwise.
- R7: Code 16 reverses the byte order of `src_a`: result byte 0 is input byte 3, byte 1 is byte 2, byte 2 is byte 1, and byte 3 is byte 0.
- R8: With bit index i taken from `src_b`, code 17 clears bit i of `src_a`, code 19 inverts it and code 20 sets it. Code 18 returns bit i of `src_a` in result bit 0, with bits 31..1 zero.
- R9: For codes 13, 14 and 17 to 20, only `src_b[4:0]` forms the amount or index. Bits 31..5 of `src_b` have no effect on the result.
- R10: Codes 21 to 31 give a result of zero.
- R11: The result depends only on the present inputs and changes in the same cycle as they do, with no state held between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (0 to 20 defined, 21 to 31 unused) |
| src_a | input | 32 | First operand: value to be operated on |
| src_b | input | 32 | Second operand: logic partner, addend, comparand, or amount/index in its low 5 bits |
| result | output | 32 | Operation result |

## Verification
All 32 codes are tried over a set of edge operands. Zero and all-ones show whether the inversions and byte tests are wired the right way. 0x80000000 and 0x7FFFFFFF set against each other tell signed from unsigned comparison. Operands with bit 7 or bit 15 set separate sign extension from zero extension. Rotations run at amounts 0, 1 and 31, and again with amount values of 32 and above, to show that high bits of the amount are dropped. Single-bit operations run at indices 0 and 31. Sum-wrapping addends show the address form truncates. A long pseudo-random run over every code then catches mixed-up lanes and wrong selections that fixed patterns would hide.

// File: rtl/bitmanip_pkg.sv
`timescale 1ns/1ps
package bitmanip_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ANDN  = 5'd0,
      OP_ORN   = 5'd1,
      OP_XNOR  = 5'd2,
      OP_SH1   = 5'd3,
      OP_SH2   = 5'd4,
      OP_SH3   = 5'd5,
      OP_MIN   = 5'd6,
      OP_MINU  = 5'd7,
      OP_MAX   = 5'd8,
      OP_MAXU  = 5'd9,
      OP_SEXTB = 5'd10,
      OP_SEXTH = 5'd11,
      OP_ZEXTH = 5'd12,
      OP_ROL   = 5'd13,
      OP_ROR   = 5'd14,
      OP_ORCB  = 5'd15,
      OP_REV8  = 5'd16,
      OP_BCLR  = 5'd17,
      OP_BEXT  = 5'd18,
      OP_BINV  = 5'd19,
      OP_BSET  = 5'd20
   } bm_op_e;

   typedef enum logic [1:0] {
      GRP_NONE  = 2'd0,
      GRP_LOGIC = 2'd1,
      GRP_ARITH = 2'd2,
      GRP_ROTB  = 2'd3
   } bm_grp_e;

   function automatic bm_grp_e group_of(logic [OP_W-1:0] op);
      case (op)
         OP_ANDN, OP_ORN, OP_XNOR, OP_SEXTB, OP_SEXTH, OP_ZEXTH,
         OP_ORCB, OP_REV8:                      return GRP_LOGIC;
         OP_SH1, OP_SH2, OP_SH3, OP_MIN, OP_MINU,
         OP_MAX, OP_MAXU:                       return GRP_ARITH;
         OP_ROL, OP_ROR, OP_BCLR, OP_BEXT,
         OP_BINV, OP_BSET:                      return GRP_ROTB;
         default:                               return GRP_NONE;
      endcase
   endfunction
endpackage

// File: rtl/bitmanip_logic_unit.sv
`timescale 1ns/1ps
module bitmanip_logic_unit
   import bitmanip_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [OP_W-1:0] op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] res
);
   localparam int NBYTES = XLEN / 8;

   logic [XLEN-1:0] orc_v;
   logic [XLEN-1:0] rev_v;

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign orc_v[8*g +: 8] = {8{|a[8*g +: 8]}};
      assign rev_v[8*g +: 8] = a[8*(NBYTES-1-g) +: 8];
   end

   always_comb begin
      case (op)
         OP_ANDN:  res = a & ~b;
         OP_ORN:   res = a | ~b;
         OP_XNOR:  res = ~(a ^ b);
         OP_SEXTB: res = {{(XLEN-8){a[7]}}, a[7:0]};
         OP_SEXTH: res = {{(XLEN-16){a[15]}}, a[15:0]};
         OP_ZEXTH: res = {{(XLEN-16){1'b0}}, a[15:0]};
         OP_ORCB:  res = orc_v;
         OP_REV8:  res = rev_v;
         default:  res = '0;
      endcase
   end

   always_comb begin
      if (op == OP_SEXTB)
         assert_sextb_top_R4: assert (res[XLEN-1] == res[7] && res[7:0] == a[7:0]);
      if (op == OP_ZEXTH)
         assert_zexth_clear_R4: assert (res[XLEN-1:16] == '0 && res[15:0] == a[15:0]);
      if (op == OP_REV8)
         assert_rev_popcount_R7: assert ($countones(res) == $countones(a));
      if (op == OP_XNOR)
         assert_xnor_disjoint_R1: assert ((res & (a ^ b)) == '0);
      if (op == OP_ORCB)
         for (int k = 0; k < NBYTES; k++)
            assert_orcb_byte_R6: assert (res[8*k +: 8] == 8'h00 || res[8*k +: 8] == 8'hFF);
   end
endmodule

// File: rtl/bitmanip_arith_unit.sv
`timescale 1ns/1ps
module bitmanip_arith_unit
   import bitmanip_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [OP_W-1:0] op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] res
);
   logic [1:0]      sh_amt;
   logic [XLEN-1:0] shifted;
   logic [XLEN-1:0] sum;
   logic            lt_u;
   logic            lt_s;

   always_comb begin
      case (op)
         OP_SH1:  sh_amt = 2'd1;
         OP_SH2:  sh_amt = 2'd2;
         default: sh_amt = 2'd3;
      endcase
   end

   assign shifted = a << sh_amt;
   assign sum     = b + shifted;
   assign lt_u    = a < b;
   assign lt_s    = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : lt_u;

   always_comb begin
      case (op)
         OP_SH1, OP_SH2, OP_SH3: res = sum;
         OP_MIN:  res = lt_s ? a : b;
         OP_MINU: res = lt_u ? a : b;
         OP_MAX:  res = lt_s ? b : a;
         OP_MAXU: res = lt_u ? b : a;
         default: res = '0;
      endcase
   end

   always_comb begin
      if (op inside {OP_MIN, OP_MINU, OP_MAX, OP_MAXU})
         assert_pick_whole_R3: assert (res == a || res == b);
      if (op == OP_MAXU)
         assert_maxu_bound_R3: assert (res >= a && res >= b);
      if (op == OP_MIN)
         assert_min_bound_R3: assert ($signed(res) <= $signed(a) && $signed(res) <= $signed(b));
      if (op == OP_SH1)
         assert_sh1_diff_R2: assert (res - b == {a[XLEN-2:0], 1'b0});
   end
endmodule

// File: rtl/bitmanip_rotbit_unit.sv
`timescale 1ns/1ps
module bitmanip_rotbit_unit
   import bitmanip_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int IDXW = $clog2(XLEN)
) (
   input  logic [OP_W-1:0] op,
   input  logic [XLEN-1:0] a,
   input  logic [IDXW-1:0] idx,
   output logic [XLEN-1:0] res
);
   logic [IDXW-1:0] left_amt;
   logic [XLEN-1:0] stage [IDXW+1];
   logic [XLEN-1:0] onehot;

   // right rotation by s equals left rotation by (XLEN - s) mod XLEN
   assign left_amt = (op == OP_ROR) ? (IDXW'(0) - idx) : idx;
   assign stage[0] = a;

   for (genvar k = 0; k < IDXW; k++) begin : g_rot
      localparam int D = 2 ** k;
      assign stage[k+1] = left_amt[k]
                        ? {stage[k][XLEN-1-D:0], stage[k][XLEN-1 -: D]}
                        : stage[k];
   end

   for (genvar i = 0; i < XLEN; i++) begin : g_dec
      assign onehot[i] = (idx == IDXW'(i));
   end

   always_comb begin
      case (op)
         OP_ROL, OP_ROR: res = stage[IDXW];
         OP_BCLR: res = a & ~onehot;
         OP_BINV: res = a ^ onehot;
         OP_BSET: res = a | onehot;
         OP_BEXT: res = {{(XLEN-1){1'b0}}, |(a & onehot)};
         default: res = '0;
      endcase
   end

   always_comb begin
      if (op == OP_ROL || op == OP_ROR) begin
         assert_rot_popcount_R5: assert ($countones(res) == $countones(a));
         if (idx == '0)
            assert_rot_zero_R5: assert (res == a);
      end
      if (op == OP_BSET)
         assert_bset_bit_R8: assert (res[idx] == 1'b1);
      if (op == OP_BCLR)
         assert_bclr_bit_R8: assert (res[idx] == 1'b0);
      if (op == OP_BEXT)
         assert_bext_shape_R8: assert (res[XLEN-1:1] == '0 && res[0] == a[idx]);
      if (op inside {OP_BCLR, OP_BINV, OP_BSET})
         assert_single_bit_R8: assert ($countones(res ^ a) <= 1);
   end
endmodule

// File: rtl/bitmanip_alu.sv
`timescale 1ns/1ps
module bitmanip_alu
   import bitmanip_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [4:0]      op_sel,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic [XLEN-1:0] result
);
   localparam int IDXW = $clog2(XLEN);

   if (XLEN < 16 || (XLEN % 8) != 0 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("bitmanip_alu: XLEN must be a power of two of at least 16");
   end

   logic [XLEN-1:0] res_logic;
   logic [XLEN-1:0] res_arith;
   logic [XLEN-1:0] res_rotb;
   bm_grp_e         grp;

   assign grp = group_of(op_sel);

   bitmanip_logic_unit #(.XLEN(XLEN)) u_logic (
      .op  (op_sel),
      .a   (src_a),
      .b   (src_b),
      .res (res_logic)
   );

   bitmanip_arith_unit #(.XLEN(XLEN)) u_arith (
      .op  (op_sel),
      .a   (src_a),
      .b   (src_b),
      .res (res_arith)
   );

   // R9: only the low index bits of src_b reach the rotate/bit unit
   bitmanip_rotbit_unit #(.XLEN(XLEN)) u_rotb (
      .op  (op_sel),
      .a   (src_a),
      .idx (src_b[IDXW-1:0]),
      .res (res_rotb)
   );

   always_comb begin
      case (grp)
         GRP_LOGIC: result = res_logic;
         GRP_ARITH: result = res_arith;
         GRP_ROTB:  result = res_rotb;
         default:   result = '0;
      endcase
   end

   always_comb begin
      if (op_sel > 5'd20)
         assert_unused_zero_R10: assert (result == '0);
      if (grp != GRP_LOGIC)
         assert_logic_idle_R11: assert (res_logic == '0);
      if (grp != GRP_ROTB)
         assert_rotb_idle_R11: assert (res_rotb == '0);
   end
endmodule

// File: tb/bitmanip_alu_bench.sv
`timescale 1ns/1ps
module bitmanip_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op_sel = 5'd0;
   logic [31:0] src_a = 32'd0;
   logic [31:0] src_b = 32'd0;
   logic [31:0] result;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   bitmanip_alu u_bitmanip_alu (
      .op_sel (op_sel),
      .src_a  (src_a),
      .src_b  (src_b),
      .result (result)
   );

   function automatic string tag_of(int op);
      if (op <= 2) return "R1";
      if (op <= 5) return "R2";
      if (op <= 9) return "R3";
      if (op <= 12) return "R4";
      if (op <= 14) return "R5";
      if (op == 15) return "R6";
      if (op == 16) return "R7";
      if (op <= 20) return "R8";
      return "R10";
   endfunction

   function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b);
      logic [31:0] r = 32'd0;
      int s = int'(b % 32);
      case (op)
         0: r = a & ~b;
         1: r = a | ~b;
         2: r = ~(a ^ b);
         3, 4, 5: r = 32'(longint'(b) + (longint'(a) * (64'd1 << (op - 2))));
         6: r = ($signed(a) < $signed(b)) ? a : b;
         7: r = (a < b) ? a : b;
         8: r = ($signed(a) > $signed(b)) ? a : b;
         9: r = (a > b) ? a : b;
         10: for (int i = 0; i < 32; i++) r[i] = (i < 8) ? a[i] : a[7];
         11: for (int i = 0; i < 32; i++) r[i] = (i < 16) ? a[i] : a[15];
         12: for (int i = 0; i < 16; i++) r[i] = a[i];
         13: for (int i = 0; i < 32; i++) r[(i + s) % 32] = a[i];
         14: for (int i = 0; i < 32; i++) r[i] = a[(i + s) % 32];
         15: for (int j = 0; j < 4; j++) r[8*j +: 8] = (a[8*j +: 8] != 0) ? 8'hFF : 8'h00;
         16: for (int j = 0; j < 4; j++) r[8*j +: 8] = a[8*(3-j) +: 8];
         17: begin r = a; r[s] = 1'b0; end
         18: r[0] = a[s];
         19: begin r = a; r[s] = ~a[s]; end
         20: begin r = a; r[s] = 1'b1; end
         default: r = 32'd0;
      endcase
      return r;
   endfunction

   task automatic apply(int op, logic [31:0] a, logic [31:0] b, string tag);
      logic [31:0] exp;
      @(posedge clk);
      op_sel = 5'(op);
      src_a  = a;
      src_b  = b;
      exp    = model(op, a, b);
      @(negedge clk);
      n_checks++;
      if (result !== exp) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, op, a, b, result, exp);
      end
   endtask

   initial begin : watchdog
      #(5.0 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] pats [8];
      logic [31:0] x = 32'h2545F491;
      pats[0] = 32'h00000000; pats[1] = 32'hFFFFFFFF;
      pats[2] = 32'h80000000; pats[3] = 32'h7FFFFFFF;
      pats[4] = 32'h00001234; pats[5] = 32'hFFFFA988;
      pats[6] = 32'h00008080; pats[7] = 32'h01FF0000;

      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle inputs after reset: code 0 with zero operands gives zero (R1, R11)
      @(negedge clk);
      n_checks++;
      if (result !== 32'd0) begin
         n_fail++;
         $display("FAIL R11 idle actual=%h expected=%h", result, 32'd0);
      end

      // every code over the edge-operand grid (R1-style tags from tag_of)
      for (int op = 0; op < 32; op++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               apply(op, pats[i], pats[j], tag_of(op));

      // wrapping shifted add (R2)
      apply(5, 32'hF0000001, 32'h80000000, "R2");
      // signed vs unsigned bounds (R3)
      apply(6, 32'h80000000, 32'h7FFFFFFF, "R3");
      apply(7, 32'h80000000, 32'h7FFFFFFF, "R3");
      // rotate amounts 0, 1, 31 (R5)
      apply(13, 32'h80000001, 32'd0, "R5");
      apply(14, 32'h80000001, 32'd1, "R5");
      apply(13, 32'h12345678, 32'd31, "R5");
      // high bits of the amount/index are dropped (R9)
      apply(13, 32'hDEADBEEF, 32'd32, "R9");
      apply(14, 32'hDEADBEEF, 32'hFFFFFFE4, "R9");
      apply(20, 32'h00000000, 32'h0000003F, "R9");
      apply(18, 32'h00000001, 32'hFFFFFFE0, "R9");
      apply(17, 32'hFFFFFFFF, 32'h80000000, "R9");
      // index edges (R8)
      apply(19, 32'h00000000, 32'd31, "R8");
      apply(18, 32'h80000000, 32'd31, "R8");
      // unused codes (R10)
      apply(21, 32'hFFFFFFFF, 32'hFFFFFFFF, "R10");
      apply(31, 32'h12345678, 32'h9ABCDEF0, "R10");

      // pseudo-random sweep over all codes
      for (int n = 0; n < 1500; n++) begin
         logic [31:0] ra, rb;
         x ^= x << 13; x ^= x >> 17; x ^= x << 5; ra = x;
         x ^= x << 13; x ^= x >> 17; x ^= x << 5; rb = x;
         apply(n % 32, ra, rb, ((n % 32) inside {13, 14, 17, 18, 19, 20}) ? "R9" : tag_of(n % 32));
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule